// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block runs one 8-pin I/O port. Each pin is a general-purpose input or output under a direction register, unless an on-chip peripheral has been enabled for it. In that case the peripheral's own data and output-enable drive the pin. For every pin the controller produces these pad-control signals:

- the driven data value
- a low-side driver enable
- a high-side driver enable
- a pullup enable
- a reduced-drive select

Pad input levels pass through a synchroniser. The synchronised levels are returned to software and are also passed to the peripherals.

Software reaches the block through a small register bus. Each write is a single-cycle strobe, and reads complete with no wait state. Pullup and reduced drive can be set either for the whole port or pin by pin. Open-drain (wired-OR) mode is set by control bits that the serial peripherals own. Each bit covers a fixed group of pins. Open-drain mode applies to a pin whether the pin is driven by a peripheral or by the GPIO output latch.

The bus has no valid/ready handshake and applies no back-pressure. A write strobe always completes in its own cycle, and read data is a combinational function of the address.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads 0. Every pin is an input: `pad_lo_en`, `pad_hi_en`, `pad_pu_en` and `pad_rd_en` are all 0.
- R2: Take a pin whose peripheral is disabled and whose direction bit is 1 (register address 1). `pad_do` equals its output-latch bit. A latch value of 1 sets `pad_hi_en`, and a latch value of 0 sets `pad_lo_en`. The two enables are never high together.
- R3: While `periph_en[i]` is 1, pin i takes its value from `periph_do[i]` and its output state from `periph_oe[i]`. Writes to the output latch during this time have no effect on the pin. They become visible once `periph_en[i]` drops.
- R4: `pad_pu_en[i]` can be 1 only when pin i is a general-purpose input, meaning its direction bit is 0 and its peripheral is disabled. On any other pin it is 0, whatever the pullup setting.
- R5: In global mode, control register (address 2) bit 2 is 0. Bit 0 of that register enables pullup on all pins, and bit 1 selects reduced drive on all pins.
- R6: In per-pin mode, control bit 2 is 1. The pullup register (address 3) and the reduced-drive register (address 4) give the setting for each pin. Control bits 0 and 1 are then ignored.
- R7: `od_lo_grp` covers pins 0–1, `od_mid_grp` covers pins 2–3 and `od_hi_grp` covers pins 4–7. While a pin's group bit is 1, `pad_hi_en` is 0 for that pin. A driven 0 still sets `pad_lo_en`, and a driven 1 releases the pin. This holds for both peripheral and GPIO drive.
- R8: A change on `pad_di` appears on `periph_di`, and in data-register reads, exactly two clock edges later. It is not visible after one edge.
- R9: A data-register read (address 0) returns the output-latch bit for output pins and the synchronised pad bit for input pins. A write to address 0 updates the latch whatever the direction bits are.
- R10: Registers read back what was written. The control register reads only its low 3 bits. Addresses 5–7 read 0, and writes to those addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, zero wait state |
| periph_en | input | 8 | Per-pin peripheral takeover |
| periph_do | input | 8 | Peripheral drive value |
| periph_oe | input | 8 | Peripheral output enable |
| periph_di | output | 8 | Synchronised pad level to peripherals |
| od_lo_grp | input | 1 | Open-drain control for pins 0–1 |
| od_mid_grp | input | 1 | Open-drain control for pins 2–3 |
| od_hi_grp | input | 1 | Open-drain control for pins 4–7 |
| pad_di | input | 8 | Raw pad input levels |
| pad_do | output | 8 | Value driven to each pad |
| pad_lo_en | output | 8 | Low-side driver enable |
| pad_hi_en | output | 8 | High-side driver enable |
| pad_pu_en | output | 8 | Pullup enable |
| pad_rd_en | output | 8 | Reduced-drive select |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both on a single falling edge.

- **Latch write during takeover.** A CPU write to the output latch arrives in the same cycle that a peripheral takes over the pins. The pads must follow the peripheral at once. The latch must still capture the write, which is judged by reading it back and by releasing the peripheral and watching the pads pick up the new value.
- **Open-drain change during a latch write.** An open-drain group bit changes in the same cycle as a latch write. The expected enables for the new value and the new mode are checked after the edge.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_PULL = 3'd3;
  localparam logic [ADDR_W-1:0] A_RDRV = 3'd4;
  localparam int CTRL_W = 3;

  typedef struct packed {
    logic per_pin;  // bit 2: per-pin pullup / reduced-drive registers
    logic rd_all;   // bit 1: reduced drive on every pin (global mode)
    logic pu_all;   // bit 0: pullup on every pin (global mode)
  } port_ctrl_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pin_sync,
  output logic [N-1:0]      latch_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      pu_sel,
  output logic [N-1:0]      rd_sel
);
  port_ctrl_t    ctrl_q;
  logic [N-1:0]  pull_q;
  logic [N-1:0]  rdrv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      ctrl_q  <= '0;
      pull_q  <= '0;
      rdrv_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA:  latch_q <= bus_wdata;
        A_DIR:   dir_q   <= bus_wdata;
        A_CTRL:  ctrl_q  <= port_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        A_PULL:  pull_q  <= bus_wdata;
        A_RDRV:  rdrv_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = (dir_q & latch_q) | (~dir_q & pin_sync);
      A_DIR:   bus_rdata = dir_q;
      A_CTRL:  bus_rdata = {{(N-CTRL_W){1'b0}}, ctrl_q};
      A_PULL:  bus_rdata = pull_q;
      A_RDRV:  bus_rdata = rdrv_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pu_sel = ctrl_q.per_pin ? pull_q : {N{ctrl_q.pu_all}};
  assign rd_sel = ctrl_q.per_pin ? rdrv_q : {N{ctrl_q.rd_all}};

  AST_LATCH_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA) |=> latch_q == $past(bus_wdata)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > A_RDRV) |-> bus_rdata == '0); // R10
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int N = 8
) (
  input  logic [N-1:0] latch_q,
  input  logic [N-1:0] dir_q,
  input  logic [N-1:0] pu_sel,
  input  logic [N-1:0] rd_sel,
  input  logic [N-1:0] periph_en,
  input  logic [N-1:0] periph_do,
  input  logic [N-1:0] periph_oe,
  input  logic [N-1:0] od_pin,
  output logic [N-1:0] pad_do,
  output logic [N-1:0] pad_lo_en,
  output logic [N-1:0] pad_hi_en,
  output logic [N-1:0] pad_pu_en,
  output logic [N-1:0] pad_rd_en
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pin
      logic drv_val;
      logic drv_on;
      always_comb begin
        drv_val      = periph_en[i] ? periph_do[i] : latch_q[i];
        drv_on       = periph_en[i] ? periph_oe[i] : dir_q[i];
        pad_do[i]    = drv_val;
        pad_lo_en[i] = drv_on & ~drv_val;
        pad_hi_en[i] = drv_on & drv_val & ~od_pin[i];
        pad_pu_en[i] = pu_sel[i] & ~periph_en[i] & ~dir_q[i];
        pad_rd_en[i] = rd_sel[i];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OD_LO_LAST  = 1,
  parameter int OD_MID_LAST = 3,
  parameter bit HAS_OD_MID  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] periph_en,
  input  logic [N_PINS-1:0] periph_do,
  input  logic [N_PINS-1:0] periph_oe,
  output logic [N_PINS-1:0] periph_di,
  input  logic              od_lo_grp,
  input  logic              od_mid_grp,
  input  logic              od_hi_grp,
  input  logic [N_PINS-1:0] pad_di,
  output logic [N_PINS-1:0] pad_do,
  output logic [N_PINS-1:0] pad_lo_en,
  output logic [N_PINS-1:0] pad_hi_en,
  output logic [N_PINS-1:0] pad_pu_en,
  output logic [N_PINS-1:0] pad_rd_en
);
  logic [N_PINS-1:0] pin_sync, latch_q, dir_q, pu_sel, rd_sel, od_pin;

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_di), .sync_out(pin_sync));

  gpio_regs #(.N(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
    .latch_q(latch_q), .dir_q(dir_q), .pu_sel(pu_sel), .rd_sel(rd_sel));

  genvar p;
  generate
    for (p = 0; p < N_PINS; p++) begin : g_od
      if (p <= OD_LO_LAST) begin : g_lo
        assign od_pin[p] = od_lo_grp;
      end else if (p <= OD_MID_LAST) begin : g_mid
        if (HAS_OD_MID) begin : g_on
          assign od_pin[p] = od_mid_grp;
        end else begin : g_off
          assign od_pin[p] = 1'b0;
        end
      end else begin : g_hi
        assign od_pin[p] = od_hi_grp;
      end
    end
  endgenerate

  gpio_pad_ctl #(.N(N_PINS)) u_pad (
    .latch_q(latch_q), .dir_q(dir_q), .pu_sel(pu_sel), .rd_sel(rd_sel),
    .periph_en(periph_en), .periph_do(periph_do), .periph_oe(periph_oe),
    .od_pin(od_pin), .pad_do(pad_do), .pad_lo_en(pad_lo_en),
    .pad_hi_en(pad_hi_en), .pad_pu_en(pad_pu_en), .pad_rd_en(pad_rd_en));

  assign periph_di = pin_sync;

  AST_RESET_ALL_INPUTS: assert property (@(posedge clk)
    !rst_n |-> (pad_lo_en | pad_hi_en | pad_pu_en | pad_rd_en) == '0); // R1
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_lo_en & pad_hi_en) == '0); // R2
  AST_PULLUP_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu_en & (pad_lo_en | pad_hi_en | periph_en)) == '0); // R4
  AST_OD_LO_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    od_lo_grp |-> pad_hi_en[OD_LO_LAST:0] == '0); // R7
  AST_OD_HI_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    od_hi_grp |-> pad_hi_en[N_PINS-1:OD_MID_LAST+1] == '0); // R7
endmodule

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
  logic       clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, periph_en = '0, periph_do = '0, periph_oe = '0, pad_di = '0;
  logic       od_lo = 1'b0, od_mid = 1'b0, od_hi = 1'b0;
  logic [7:0] bus_rdata, periph_di, pad_do, lo_en, hi_en, pu_en, rd_en;
  int nvec = 0, nbad = 0;

  always #2 clk = ~clk;

  gpio_mux_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_en(periph_en),
    .periph_do(periph_do), .periph_oe(periph_oe), .periph_di(periph_di),
    .od_lo_grp(od_lo), .od_mid_grp(od_mid), .od_hi_grp(od_hi),
    .pad_di(pad_di), .pad_do(pad_do), .pad_lo_en(lo_en), .pad_hi_en(hi_en),
    .pad_pu_en(pu_en), .pad_rd_en(rd_en));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [7:0] exp);
    bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 lo_en in reset", lo_en, 8'h00);
    chk("R1 pu_en in reset", pu_en, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd_chk("R1 reg after reset", 3'(a), 8'h00);
    chk("R1 hi_en", hi_en, 8'h00);
    chk("R1 rd_en", rd_en, 8'h00);
  endtask

  task automatic t_gpio_out;
    wr(3'd1, 8'hFF); wr(3'd0, 8'hA5); #1;
    chk("R2 pad_do", pad_do, 8'hA5);
    chk("R2 hi_en", hi_en, 8'hA5);
    chk("R2 lo_en", lo_en, 8'h5A);
    wr(3'd2, 8'h01); #1;
    chk("R4 no pullup on outputs", pu_en, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_periph;
    periph_en = 8'h0F; periph_do = 8'h03; periph_oe = 8'h0F; #1;
    chk("R3 pad_do mixed", pad_do, 8'hA3);
    chk("R3 hi_en mixed", hi_en, 8'hA3);
    chk("R3 lo_en mixed", lo_en, 8'h5C);
    // takeover and latch write fall in the same cycle
    @(negedge clk);
    periph_en = 8'hFF; periph_do = 8'h00; periph_oe = 8'h00;
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h3C;
    @(negedge clk); bus_wr = 1'b0; #1;
    chk("R3 pads follow peripheral", lo_en | hi_en, 8'h00);
    chk("R3 pad_do from peripheral", pad_do, 8'h00);
    rd_chk("R3 latch took write", 3'd0, 8'h3C);
    periph_en = 8'h00; #1;
    chk("R3 latch visible on release", hi_en, 8'h3C);
    chk("R3 latch low side on release", lo_en, 8'hC3);
  endtask

  task automatic t_global;
    wr(3'd1, 8'h00); wr(3'd2, 8'h03); #1;
    chk("R5 global pullup", pu_en, 8'hFF);
    chk("R5 global reduced drive", rd_en, 8'hFF);
    periph_en = 8'h0F; #1;
    chk("R4 no pullup on peripheral pins", pu_en, 8'hF0);
    periph_en = 8'h00;
    wr(3'd1, 8'h0F); #1;
    chk("R4 no pullup on output pins", pu_en, 8'hF0);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); #1;
    chk("R5 global off", pu_en | rd_en, 8'h00);
  endtask

  task automatic t_perpin;
    wr(3'd3, 8'h3C); wr(3'd4, 8'h81); #1;
    chk("R5 per-pin regs ignored in global mode", pu_en | rd_en, 8'h00);
    wr(3'd2, 8'h04); #1;
    chk("R6 per-pin pullup", pu_en, 8'h3C);
    chk("R6 per-pin reduced drive", rd_en, 8'h81);
    wr(3'd2, 8'hFF); #1;
    chk("R6 global bits ignored", pu_en, 8'h3C);
    rd_chk("R10 ctrl low bits only", 3'd2, 8'h07);
    rd_chk("R10 pull readback", 3'd3, 8'h3C);
    rd_chk("R10 rdrv readback", 3'd4, 8'h81);
    wr(3'd5, 8'hFF); wr(3'd7, 8'hAA);
    rd_chk("R10 unmapped 5", 3'd5, 8'h00);
    rd_chk("R10 unmapped 7", 3'd7, 8'h00);
    rd_chk("R10 dir untouched by unmapped write", 3'd1, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_open_drain;
    wr(3'd1, 8'hFF); wr(3'd0, 8'hFF);
    od_lo = 1'b1; #1;
    chk("R7 lo group hi_en", hi_en, 8'hFC);
    chk("R7 lo group released", lo_en, 8'h00);
    od_lo = 1'b0; od_mid = 1'b1; #1;
    chk("R7 mid group hi_en", hi_en, 8'hF3);
    od_mid = 1'b0; od_hi = 1'b1; #1;
    chk("R7 hi group hi_en", hi_en, 8'h0F);
    // mode change and latch write in the same cycle
    @(negedge clk);
    od_lo = 1'b1; od_mid = 1'b1;
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h55;
    @(negedge clk); bus_wr = 1'b0; #1;
    chk("R7 all groups hi_en", hi_en, 8'h00);
    chk("R7 driven zeros pull low", lo_en, 8'hAA);
    od_mid = 1'b0; od_hi = 1'b0;
    wr(3'd0, 8'hFF);
    periph_en = 8'h03; periph_do = 8'h01; periph_oe = 8'h03; #1;
    chk("R7 peripheral hi_en", hi_en, 8'hFC);
    chk("R7 peripheral lo_en", lo_en, 8'h02);
    periph_en = 8'h00; od_lo = 1'b0;
  endtask

  task automatic t_sync;
    wr(3'd1, 8'h00);
    bus_addr = 3'd0;
    @(negedge clk); pad_di = 8'h3C;
    @(posedge clk); #1;
    chk("R8 one edge not visible", bus_rdata, 8'h00);
    chk("R8 periph_di one edge", periph_di, 8'h00);
    @(posedge clk); #1;
    chk("R8 two edges visible", bus_rdata, 8'h3C);
    chk("R8 periph_di two edges", periph_di, 8'h3C);
  endtask

  task automatic t_mix;
    wr(3'd1, 8'hF0); wr(3'd0, 8'hAA);
    pad_di = 8'h0F;
    repeat (3) @(negedge clk);
    rd_chk("R9 mixed data read", 3'd0, 8'hAF);
    wr(3'd1, 8'h00); wr(3'd0, 8'h55);
    rd_chk("R9 inputs read pad", 3'd0, 8'h0F);
    wr(3'd1, 8'hFF);
    rd_chk("R9 latch written while input", 3'd0, 8'h55);
  endtask

  initial begin
    #(4 * 20000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_gpio_out();
    t_periph();
    t_global();
    t_perpin();
    t_open_drain();
    t_sync();
    t_mix();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule